// File: doc/BRIEF.md
# E1 Digital Clock Recovery

This block rebuilds the 2.048 MHz bit clock of a received E1 stream. It works from a free-running reference at sixteen times the bit rate, so no tuned external part is needed. A 4-bit phase counter wraps once per bit. The rising edge of each received return-to-zero pulse is compared with the counter. When the pulse arrives early or late, the next bit period is made one reference cycle longer or shorter. Each bit period gets at most one such step, and none at all while loss of signal is flagged.

The recovered clock comes straight from the counter, high for half the bit and low for the other half. Its active edge sits at the centre of the received pulse. A strap selects whether that edge is rising or falling. The received level is sampled at the mid-pulse point. It is presented as a retimed bit together with a one-cycle strobe. While loss of signal is flagged, the counter free-runs at exactly sixteen reference cycles per bit and the retimed bit reads zero.

Top module: `e1_clk_recovery`

## Requirements
- R1: While `rst_n` is low, `rx_stb` and `rx_bit` are 0 and `rec_clk` equals the inverse of `edge_pol`.
- R2: With no pulse edges received, `rx_stb` asserts exactly once every 16 cycles, and `rec_clk` is high for 8 of every 16 cycles.
- R3: In every cycle where `rx_stb` is 1, `rec_clk` equals `edge_pol`, and two cycles earlier it equalled the inverse. With the strap at 1 the mid-pulse edge is therefore rising; with the strap at 0 it is falling.
- R4: Feed pulses that are 8 cycles high every 16 cycles, starting at any phase. After 24 bit periods, `rx_stb` is seen high 6 cycles after the cycle in which `rx_pulse` is first driven high for the bit. Put another way, it is visible after the fifth clock edge that follows the first edge sampling the pulse high.
- R5: The spacing between consecutive strobes is always 15, 16 or 17 cycles. This holds even when a bit carries several pulse edges, because the phase moves by at most one count per bit.
- R6: Once locked, `rx_bit` presented with each strobe is 1 for a bit that carried a pulse and 0 for a bit that carried none.
- R7: While `los` is 1, pulses at any phase apply no correction: strobe spacing stays exactly 16.
- R8: A strobe issued while `los` is 1 carries `rx_bit` = 0, whatever the line input.
- R9: `rx_stb` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling reference, 16x the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pulse | input | 1 | Merged received RZ pulse signal, 1 = mark |
| los | input | 1 | Loss-of-signal flag, 1 = signal lost |
| edge_pol | input | 1 | Strap: 1 = rising clock edge at pulse centre, 0 = falling |
| rec_clk | output | 1 | Recovered bit clock |
| rx_bit | output | 1 | Retimed received bit |
| rx_stb | output | 1 | One-cycle strobe that qualifies `rx_bit` |

## Verification
A correction decided earlier in the bit is applied in the counter's last count. A fresh pulse edge can land in that same cycle, and it must not be lost or applied twice. The sweep over all sixteen starting offsets drives pulse edges onto every counter value, including the wrap count. It judges the result by strobe spacing staying within 15 to 17 cycles and by the final lock position. Loss of signal arriving while a correction is pending is the second collision. The bench raises the flag on a stream that is still producing edges and then requires spacing of exactly 16 and a zero data bit.

// File: rtl/e1_clk_recovery.sv
module e1_clk_recovery #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pulse,
  input  logic los,
  input  logic edge_pol,
  output logic rec_clk,
  output logic rx_bit,
  output logic rx_stb
);
  localparam int PW   = $clog2(OSR);
  localparam int MID  = OSR / 2;
  localparam int TGT  = MID - OSR / 4;
  localparam int LAST = OSR - 1;

  localparam logic [1:0] NONE = 2'b00;
  localparam logic [1:0] SLOW = 2'b01;
  localparam logic [1:0] FAST = 2'b10;

  logic [PW-1:0] ph, ph_n, diff;
  logic [1:0]    pend, pend_n, dir_new;
  logic          rx_s, rx_d, held, wrap, apply, edge_seen;

  assign edge_seen = rx_s & ~rx_d & ~los;
  assign diff      = ph - PW'(TGT);
  assign dir_new   = (diff == '0) ? NONE : (diff < PW'(MID)) ? SLOW : FAST;
  assign wrap      = (ph == PW'(LAST));
  assign apply     = wrap & ~held & ~los;

  always_comb begin
    ph_n = ph + 1'b1;
    if (apply && pend == SLOW) ph_n = PW'(LAST);
    else if (apply && pend == FAST) ph_n = PW'(1);
  end

  always_comb begin
    if (los)                          pend_n = NONE;
    else if (wrap && !held)           pend_n = edge_seen ? dir_new : NONE;
    else if (pend == NONE && edge_seen) pend_n = dir_new;
    else                              pend_n = pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      pend   <= NONE;
      held   <= 1'b0;
      rx_s   <= 1'b0;
      rx_d   <= 1'b0;
      rx_bit <= 1'b0;
      rx_stb <= 1'b0;
    end else begin
      ph     <= ph_n;
      pend   <= pend_n;
      held   <= apply && pend == SLOW;
      rx_s   <= rx_pulse;
      rx_d   <= rx_s;
      rx_stb <= (ph == PW'(MID));
      if (ph == PW'(MID)) rx_bit <= rx_s & ~los;
    end
  end

  assign rec_clk = (ph >= PW'(MID)) ^ ~edge_pol;
endmodule

module e1_clk_recovery_chk #(
  parameter int OSR = 16
) (
  input logic clk,
  input logic rst_n,
  input logic los,
  input logic edge_pol,
  input logic rec_clk,
  input logic rx_bit,
  input logic rx_stb
);
  localparam int GW = $clog2(OSR) + 2;
  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (rx_stb) begin
      gap  <= GW'(1);
      seen <= 1'b1;
    end else if (gap != '1) begin
      gap <= gap + 1'b1;
    end
  end

  p_stb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |=> !rx_stb);

  p_stb_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && seen) |-> (gap >= GW'(OSR - 1) && gap <= GW'(OSR + 1)));

  p_los_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && $past(los)) |-> !rx_bit);

  p_edge_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_stb) && $stable(edge_pol)) |-> (rec_clk == edge_pol));

  p_edge_before_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_stb) && $stable(edge_pol) && $past(edge_pol) == $past(edge_pol, 2))
      |-> ($past(rec_clk, 2) != edge_pol));
endmodule

bind e1_clk_recovery e1_clk_recovery_chk #(.OSR(OSR)) u_chk (
  .clk(clk), .rst_n(rst_n), .los(los), .edge_pol(edge_pol),
  .rec_clk(rec_clk), .rx_bit(rx_bit), .rx_stb(rx_stb)
);

// File: tb/e1_clk_recovery_bench.sv
module e1_clk_recovery_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, rx_pulse = 1'b0, los = 1'b0, edge_pol = 1'b0;
  logic rec_clk, rx_bit, rx_stb;

  always #2 clk = ~clk;

  e1_clk_recovery u_e1_clk_recovery (
    .clk(clk), .rst_n(rst_n), .rx_pulse(rx_pulse), .los(los), .edge_pol(edge_pol),
    .rec_clk(rec_clk), .rx_bit(rx_bit), .rx_stb(rx_stb)
  );

  int total = 0, bad = 0;
  int iter = 0, last_stb = -1, slot_start = 0, hi_cnt = 0;
  logic cur_bit = 1'b0, h1 = 1'b0, h2 = 1'b0, pstb = 1'b0;
  bit chk_align = 0, chk_space = 0, exact = 0, los_mode = 0, done = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at step %0d", req, act, exp, iter);
    end
  endtask

  task automatic step(input logic p, input bit first, input logic b);
    int sp;
    @(negedge clk);
    iter++;
    if (rec_clk) hi_cnt++;
    if (rx_stb) begin
      check(!pstb, "R9", int'(pstb), 0);
      if (chk_space && last_stb >= 0) begin
        sp = iter - last_stb;
        if (exact) check(sp == 16, los_mode ? "R7" : "R2", sp, 16);
        else       check(sp >= 15 && sp <= 17, "R5", sp, 16);
      end
      last_stb = iter;
      check(rec_clk == edge_pol && h2 == ~edge_pol, "R3",
            int'({h2, rec_clk}), int'({~edge_pol, edge_pol}));
      if (chk_align) begin
        check(iter - slot_start == 6, "R4", iter - slot_start, 6);
        check(rx_bit == cur_bit, "R6", int'(rx_bit), int'(cur_bit));
      end
      if (los_mode) check(rx_bit == 1'b0, "R8", int'(rx_bit), 0);
    end
    h2 = h1; h1 = rec_clk; pstb = rx_stb;
    if (first) begin slot_start = iter; cur_bit = b; end
    rx_pulse = p;
  endtask

  task automatic send_bit(input logic b, input int sh);
    for (int j = 0; j < 16; j++) step(b && j >= sh && j < sh + 8, j == sh, b);
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset(input logic pol);
    @(negedge clk);
    rst_n = 1'b0; edge_pol = pol; rx_pulse = 1'b0; los = 1'b0;
    repeat (3) @(negedge clk);
    check(rx_stb == 1'b0 && rx_bit == 1'b0, "R1", int'({rx_stb, rx_bit}), 0);
    check(rec_clk == ~pol, "R1", int'(rec_clk), int'(~pol));
    rst_n = 1'b1;
    last_stb = -1; pstb = 1'b0; h1 = ~pol; h2 = ~pol;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R2: free run with no edges, both strap values
    for (int pol = 0; pol < 2; pol++) begin
      do_reset(pol[0]);
      chk_space = 1; exact = 1;
      idle(16);
      hi_cnt = 0;
      idle(64);
      check(hi_cnt == 32, "R2", hi_cnt, 32);
      exact = 0; chk_space = 0;
    end

    // R4/R5/R6: lock from every starting offset, then random data
    for (int k = 0; k < 16; k++) begin
      do_reset(k[0]);
      chk_space = 1; chk_align = 0;
      idle(k);
      repeat (24) send_bit(1'b1, 0);
      chk_align = 1;
      repeat (8) send_bit(1'b1, 0);
      for (int n = 0; n < 32; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        send_bit(lfsr[0], 0);
      end
      chk_align = 0;
    end

    // R5: several edges per bit still move phase by at most one count
    for (int n = 0; n < 16; n++)
      for (int j = 0; j < 16; j++)
        step(j < 3 || (j >= 5 && j < 7) || (j >= 9 && j < 11) || j == 13, 1'b0, 1'b1);

    // R7/R8: loss of signal with misaligned pulses
    repeat (8) send_bit(1'b1, 0);
    los = 1'b1; los_mode = 1; exact = 1; last_stb = -1;
    repeat (20) send_bit(1'b1, 5);
    exact = 0; los_mode = 0; last_stb = -1;
    los = 1'b0;
    // relock to shifted phase after release (R4)
    repeat (24) send_bit(1'b1, 5);
    chk_align = 1;
    repeat (8) send_bit(1'b1, 5);
    chk_align = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule